// File: doc/BRIEF.md
# Address-Match Watch Unit

This unit observes a CPU's data bus (read and write strobes with an address) and its instruction-fetch port, and compares each qualified access against two programmable compare addresses. In normal mode a qualified access whose address equals either compare address records a hit. In range mode it records a hit when the address falls between the two compare addresses, both ends included. Each kind of hit sets its own sticky status bit. Software clears a bit by writing 1 to it.

A pending output stays high while any status bit is set. When the halt enable is set, every cycle that produces a hit raises a halt request to the CPU on the following cycle, for one cycle. Registers are reached through a small select/write-enable/data bus with a combinational read port. Range support is chosen at build time. Several copies may sit side by side, one per watch channel.

Top module: `addr_watch_unit`

## Requirements
- R1: After reset the control register, both compare addresses and the status register read 0, and `pending` and `halt_req` are 0.
- R2: Register select 0 is control, 1 is status, 2 is compare address A, 3 is compare address B. Writes to 0, 2 and 3 read back on the next cycle. Control bits are [0] halt enable, [1] fetch mode, [2] read enable, [3] write enable, [4] range mode. Unused control bits read 0.
- R3: Outside range mode, a qualified read at address A sets status bit 0 and a qualified write at A sets bit 1. At address B a read sets bit 2 and a write sets bit 3. The bits become visible one cycle after the access.
- R4: A read is qualified only while the read enable is set, and a write only while the write enable is set.
- R5: In range mode a qualified read with A ≤ address ≤ B sets status bit 4, and a qualified write in that range sets bit 5. Bits 0 to 3 are not set in range mode. When A > B the range is empty.
- R6: In fetch mode the fetch port (`fetch_vld`, `fetch_addr`) replaces the data bus as the source of read hits. Data-bus reads and writes record nothing.
- R7: Status bits are sticky. Writing status with a 1 clears that bit and a 0 leaves it unchanged. A hit in the same cycle as a clear wins.
- R8: `pending` is 1 exactly when the status register is nonzero.
- R9: With the halt enable set, `halt_req` is 1 in the cycle after each cycle that produced a hit, and 0 otherwise. With the halt enable clear it stays 0.
- R10: When built without range support, the range-mode control bit reads 0, matching stays in normal mode, and status bits 4 and 5 stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Read data of the selected register (combinational) |
| bus_addr | input | AW | Data access address |
| bus_rd | input | 1 | Data read strobe |
| bus_wr | input | 1 | Data write strobe |
| fetch_vld | input | 1 | Instruction fetch strobe |
| fetch_addr | input | AW | Instruction fetch address |
| pending | output | 1 | Some status bit is set |
| halt_req | output | 1 | One-cycle halt request after a hit |

## Verification
The bench builds two copies from the same stimulus. One has 16-bit addresses and data with range support on. The other is identical except that range support is off. Running both side by side lets the same range-mode programming be checked both ways: as inclusive range hits in the first copy, and as plain equality hits with a masked mode bit in the second. The 16-bit width lets the bench place compare addresses freely, including reversed bounds and addresses one below or one above a bound.

// File: rtl/awu_pkg.sv
package awu_pkg;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_ADRA = 2'd2;
  localparam logic [1:0] SEL_ADRB = 2'd3;

  localparam int NUM_REF  = 2;
  localparam int ST_W     = 2 * NUM_REF + 2;
  localparam int ST_RG_RD = 2 * NUM_REF;
  localparam int ST_RG_WR = 2 * NUM_REF + 1;

  typedef struct packed {
    logic range_sel;
    logic wr_en;
    logic rd_en;
    logic fetch_sel;
    logic halt_en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  typedef logic [31:0] wide_t;

  function automatic logic addr_eq(wide_t a, wide_t b);
    return a == b;
  endfunction

  function automatic logic addr_within(wide_t a, wide_t lo, wide_t hi);
    return (a >= lo) && (a <= hi);
  endfunction

  function automatic logic [ST_W-1:0] sticky_next(logic [ST_W-1:0] cur,
                                                  logic [ST_W-1:0] clr,
                                                  logic [ST_W-1:0] set);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/awu_regs.sv
module awu_regs
  import awu_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int RANGE_EN = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      reg_sel,
  input  logic            reg_we,
  input  logic [DW-1:0]   reg_wdata,
  input  logic [ST_W-1:0] hit_vec,
  output ctrl_t           ctrl_q,
  output logic [AW-1:0]   addra_q,
  output logic [AW-1:0]   addrb_q,
  output logic [ST_W-1:0] status_q,
  output logic [ST_W-1:0] clr_vec,
  output logic [DW-1:0]   reg_rdata
);

  ctrl_t ctrl_d;
  logic  we_ctrl, we_adra, we_adrb, we_stat;

  assign we_ctrl = reg_we && (reg_sel == SEL_CTRL);
  assign we_stat = reg_we && (reg_sel == SEL_STAT);
  assign we_adra = reg_we && (reg_sel == SEL_ADRA);
  assign we_adrb = reg_we && (reg_sel == SEL_ADRB);

  assign clr_vec = we_stat ? reg_wdata[ST_W-1:0] : '0;

  always_comb begin
    ctrl_d = ctrl_t'(reg_wdata[CTRL_W-1:0]);
    if (RANGE_EN == 0) ctrl_d.range_sel = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      addra_q  <= '0;
      addrb_q  <= '0;
      status_q <= '0;
    end else begin
      if (we_ctrl) ctrl_q  <= ctrl_d;
      if (we_adra) addra_q <= reg_wdata[AW-1:0];
      if (we_adrb) addrb_q <= reg_wdata[AW-1:0];
      status_q <= sticky_next(status_q, clr_vec, hit_vec);
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_CTRL: reg_rdata[CTRL_W-1:0] = ctrl_q;
      SEL_STAT: reg_rdata[ST_W-1:0]   = status_q;
      SEL_ADRA: reg_rdata[AW-1:0]     = addra_q;
      default:  reg_rdata[AW-1:0]     = addrb_q;
    endcase
  end

endmodule

// File: rtl/awu_match.sv
module awu_match
  import awu_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0]      obs_addr,
  input  logic [AW-1:0]      addra_q,
  input  logic [AW-1:0]      addrb_q,
  output logic [NUM_REF-1:0] eq_vec,
  output logic               in_rng
);

  logic [AW-1:0] ref_addr [NUM_REF];

  assign ref_addr[0] = addra_q;
  assign ref_addr[1] = addrb_q;

  for (genvar g = 0; g < NUM_REF; g++) begin : g_cmp
    assign eq_vec[g] = addr_eq(wide_t'(obs_addr), wide_t'(ref_addr[g]));
  end

  assign in_rng = addr_within(wide_t'(obs_addr), wide_t'(addra_q), wide_t'(addrb_q));

endmodule

// File: rtl/awu_event.sv
module awu_event
  import awu_pkg::*;
#(
  parameter int RANGE_EN = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ctrl_t              ctrl_q,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic               fetch_vld,
  input  logic [NUM_REF-1:0] eq_vec,
  input  logic               in_rng,
  output logic               rd_evt,
  output logic               wr_evt,
  output logic               range_act,
  output logic [ST_W-1:0]    hit_vec,
  output logic               halt_req
);

  assign rd_evt = ctrl_q.rd_en && (ctrl_q.fetch_sel ? fetch_vld : bus_rd);
  assign wr_evt = ctrl_q.wr_en && !ctrl_q.fetch_sel && bus_wr;

  for (genvar g = 0; g < NUM_REF; g++) begin : g_pt
    assign hit_vec[2*g]   = !range_act && rd_evt && eq_vec[g];
    assign hit_vec[2*g+1] = !range_act && wr_evt && eq_vec[g];
  end

  if (RANGE_EN != 0) begin : g_rng
    assign range_act         = ctrl_q.range_sel;
    assign hit_vec[ST_RG_RD] = range_act && rd_evt && in_rng;
    assign hit_vec[ST_RG_WR] = range_act && wr_evt && in_rng;
  end else begin : g_norng
    logic unused_rng;
    assign unused_rng        = in_rng ^ ctrl_q.range_sel;
    assign range_act         = 1'b0;
    assign hit_vec[ST_RG_RD] = 1'b0;
    assign hit_vec[ST_RG_WR] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halt_req <= 1'b0;
    else        halt_req <= ctrl_q.halt_en && (hit_vec != '0);
  end

endmodule

// File: rtl/addr_watch_unit.sv
module addr_watch_unit
  import awu_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int RANGE_EN = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    reg_sel,
  input  logic          reg_we,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic          fetch_vld,
  input  logic [AW-1:0] fetch_addr,
  output logic          pending,
  output logic          halt_req
);

  ctrl_t               ctrl_q;
  logic [AW-1:0]       addra_q, addrb_q, obs_addr;
  logic [ST_W-1:0]     status_q, clr_vec, hit_vec;
  logic [NUM_REF-1:0]  eq_vec;
  logic                in_rng, rd_evt, wr_evt, range_act;
  logic                halt_en_w, fetch_sel_w;

  assign halt_en_w   = ctrl_q.halt_en;
  assign fetch_sel_w = ctrl_q.fetch_sel;
  assign obs_addr    = fetch_sel_w ? fetch_addr : bus_addr;

  awu_regs #(.AW(AW), .DW(DW), .RANGE_EN(RANGE_EN)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .hit_vec(hit_vec), .ctrl_q(ctrl_q),
    .addra_q(addra_q), .addrb_q(addrb_q), .status_q(status_q),
    .clr_vec(clr_vec), .reg_rdata(reg_rdata)
  );

  awu_match #(.AW(AW)) u_match (
    .obs_addr(obs_addr), .addra_q(addra_q), .addrb_q(addrb_q),
    .eq_vec(eq_vec), .in_rng(in_rng)
  );

  awu_event #(.RANGE_EN(RANGE_EN)) u_event (
    .clk(clk), .rst_n(rst_n), .ctrl_q(ctrl_q), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .fetch_vld(fetch_vld), .eq_vec(eq_vec),
    .in_rng(in_rng), .rd_evt(rd_evt), .wr_evt(wr_evt),
    .range_act(range_act), .hit_vec(hit_vec), .halt_req(halt_req)
  );

  assign pending = |status_q;

endmodule

// File: rtl/awu_chk.sv
module awu_chk
  import awu_pkg::*;
#(
  parameter int RANGE_EN = 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [ST_W-1:0] hit_vec,
  input logic [ST_W-1:0] status_q,
  input logic [ST_W-1:0] clr_vec,
  input logic            halt_req,
  input logic            pending,
  input logic            halt_en,
  input logic            fetch_sel,
  input logic            range_act
);

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (((($past(status_q) & ~$past(clr_vec)) & ~status_q)) == '0)); // R7

  AST_HIT_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec != '0) |=> (($past(hit_vec) & ~status_q) == '0)); // R3

  AST_HALT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> $past(halt_en && (hit_vec != '0))); // R9

  AST_HALT_GIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_en && (hit_vec != '0)) |=> halt_req); // R9

  AST_RANGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    range_act |-> (hit_vec[ST_RG_RD-1:0] == '0)); // R5

  AST_NORMAL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !range_act |-> (hit_vec[ST_RG_WR:ST_RG_RD] == '0)); // R5

  AST_FETCH_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_sel |-> (hit_vec[1] == 1'b0 && hit_vec[3] == 1'b0 && hit_vec[ST_RG_WR] == 1'b0)); // R6

  AST_PEND_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> $past(hit_vec != '0)); // R8

  if (RANGE_EN == 0) begin : g_norng
    AST_NO_RANGE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      status_q[ST_RG_WR:ST_RG_RD] == 2'b00); // R10
  end

endmodule

bind addr_watch_unit awu_chk #(.RANGE_EN(RANGE_EN)) u_chk (
  .clk(clk), .rst_n(rst_n), .hit_vec(hit_vec), .status_q(status_q),
  .clr_vec(clr_vec), .halt_req(halt_req), .pending(pending),
  .halt_en(halt_en_w), .fetch_sel(fetch_sel_w), .range_act(range_act)
);

// File: tb/tb_addr_watch_unit.sv
module tb_addr_watch_unit;
  localparam int AW = 16;
  localparam int DW = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [1:0]    reg_sel = 2'd1;
  logic          reg_we = 1'b0;
  logic [DW-1:0] reg_wdata = '0;
  logic [AW-1:0] bus_addr = '0, fetch_addr = '0;
  logic          bus_rd = 1'b0, bus_wr = 1'b0, fetch_vld = 1'b0;
  logic [DW-1:0] rdata [2];
  logic          pend [2];
  logic          halt [2];

  addr_watch_unit #(.AW(AW), .DW(DW), .RANGE_EN(1)) dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(rdata[0]), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .fetch_vld(fetch_vld),
    .fetch_addr(fetch_addr), .pending(pend[0]), .halt_req(halt[0])
  );

  addr_watch_unit #(.AW(AW), .DW(DW), .RANGE_EN(0)) dut_nr (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(rdata[1]), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .fetch_vld(fetch_vld),
    .fetch_addr(fetch_addr), .pending(pend[1]), .halt_req(halt[1])
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  // Behavioural reference: one state set per copy (0 with range, 1 without)
  int m_ctrl [2], m_a [2], m_b [2], m_st [2];
  bit m_halt [2];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) begin
        m_ctrl[k] = 0; m_a[k] = 0; m_b[k] = 0; m_st[k] = 0; m_halt[k] = 0;
      end
    end else begin
      for (int k = 0; k < 2; k++) begin
        int ctl, adr, h;
        bit r, w;
        ctl = m_ctrl[k];
        adr = ctl[1] ? int'(fetch_addr) : int'(bus_addr);
        r = ctl[2] && (ctl[1] ? fetch_vld : bus_rd);
        w = ctl[3] && !ctl[1] && bus_wr;
        h = 0;
        if (ctl[4]) begin
          if (adr >= m_a[k] && adr <= m_b[k]) begin
            if (r) h |= 16;
            if (w) h |= 32;
          end
        end else begin
          if (adr == m_a[k]) begin if (r) h |= 1; if (w) h |= 2; end
          if (adr == m_b[k]) begin if (r) h |= 4; if (w) h |= 8; end
        end
        m_halt[k] = ctl[0] && (h != 0);
        if (reg_we) begin
          case (reg_sel)
            2'd0: m_ctrl[k] = int'(reg_wdata) & ((k == 0) ? 31 : 15);
            2'd1: m_st[k]   = m_st[k] & ~(int'(reg_wdata) & 63);
            2'd2: m_a[k]    = int'(reg_wdata);
            default: m_b[k] = int'(reg_wdata);
          endcase
        end
        m_st[k] |= h;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < 2; k++) begin
        int e;
        case (reg_sel)
          2'd0: e = m_ctrl[k];
          2'd1: e = m_st[k];
          2'd2: e = m_a[k];
          default: e = m_b[k];
        endcase
        check("R2", "model rdata", 32'(rdata[k]), e);
        check("R8", "model pending", 32'(pend[k]), 32'(m_st[k] != 0));
        check("R9", "model halt", 32'(halt[k]), 32'(m_halt[k]));
      end
    end
  end

  task automatic cyc(logic [1:0] s, logic we, logic [15:0] wd, logic [15:0] ba,
                     logic r, logic w, logic fv, logic [15:0] fa);
    @(negedge clk); #1;
    reg_sel = s; reg_we = we; reg_wdata = wd;
    bus_addr = ba; bus_rd = r; bus_wr = w; fetch_vld = fv; fetch_addr = fa;
    @(posedge clk); #1;
    reg_we = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0; fetch_vld = 1'b0;
  endtask

  task automatic wreg(logic [1:0] s, logic [15:0] d);
    cyc(s, 1'b1, d, 16'h0, 1'b0, 1'b0, 1'b0, 16'h0);
  endtask

  task automatic bus(logic [15:0] a, logic r, logic w);
    cyc(2'd1, 1'b0, 16'h0, a, r, w, 1'b0, 16'h0);
  endtask

  task automatic fetch(logic [15:0] a);
    cyc(2'd1, 1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b1, a);
  endtask

  task automatic rd_chk(int k, logic [1:0] s, logic [15:0] exp, string req);
    reg_sel = s; #1;
    check(req, "register", 32'(rdata[k]), 32'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", "pending in reset", 32'(pend[0]), 0);
    check("R1", "halt in reset", 32'(halt[0]), 0);
    @(negedge clk); rst_n = 1'b1;
    for (int s = 0; s < 4; s++) rd_chk(0, 2'(s), 16'h0, "R1");

    // R2: programming and read-back, unused control bits read 0
    wreg(2'd2, 16'h1000);
    wreg(2'd3, 16'h1010);
    wreg(2'd0, 16'hFFED);
    rd_chk(0, 2'd0, 16'd13, "R2");
    rd_chk(0, 2'd2, 16'h1000, "R2");
    rd_chk(0, 2'd3, 16'h1010, "R2");
    rd_chk(1, 2'd0, 16'd13, "R2");

    // R3 / R9 / R8: write hit on address A, then read hit on B
    bus(16'h1000, 1'b0, 1'b1);
    check("R9", "halt after hit", 32'(halt[0]), 1);
    check("R8", "pending after hit", 32'(pend[0]), 1);
    rd_chk(0, 2'd1, 16'h0002, "R3");
    bus(16'h0000, 1'b0, 1'b0);
    check("R9", "halt one cycle", 32'(halt[0]), 0);
    bus(16'h1010, 1'b1, 1'b0);
    rd_chk(0, 2'd1, 16'h0006, "R3");

    // R7: write-one-to-clear
    wreg(2'd1, 16'h0002);
    rd_chk(0, 2'd1, 16'h0004, "R7");
    wreg(2'd1, 16'h0000);
    rd_chk(0, 2'd1, 16'h0004, "R7");
    wreg(2'd1, 16'h003F);
    check("R8", "pending cleared", 32'(pend[0]), 0);

    // R4: qualification by kind; R9 no halt when disabled
    wreg(2'd0, 16'd8);
    bus(16'h1000, 1'b1, 1'b0);
    rd_chk(0, 2'd1, 16'h0000, "R4");
    bus(16'h1000, 1'b0, 1'b1);
    check("R9", "no halt when disabled", 32'(halt[0]), 0);
    rd_chk(0, 2'd1, 16'h0002, "R4");
    wreg(2'd1, 16'h003F);
    wreg(2'd0, 16'd4);
    bus(16'h1010, 1'b0, 1'b1);
    rd_chk(0, 2'd1, 16'h0000, "R4");
    bus(16'h1010, 1'b1, 1'b0);
    rd_chk(0, 2'd1, 16'h0004, "R4");
    wreg(2'd1, 16'h003F);

    // R5 range mode inclusive; R10 build without range
    wreg(2'd0, 16'd28);
    rd_chk(1, 2'd0, 16'd12, "R10");
    bus(16'h1000, 1'b1, 1'b0);
    rd_chk(0, 2'd1, 16'h0010, "R5");
    rd_chk(1, 2'd1, 16'h0001, "R10");
    wreg(2'd1, 16'h003F);
    bus(16'h1010, 1'b0, 1'b1);
    rd_chk(0, 2'd1, 16'h0020, "R5");
    rd_chk(1, 2'd1, 16'h0008, "R10");
    wreg(2'd1, 16'h003F);
    bus(16'h1011, 1'b1, 1'b0);
    bus(16'h0FFF, 1'b0, 1'b1);
    rd_chk(0, 2'd1, 16'h0000, "R5");
    bus(16'h1008, 1'b1, 1'b1);
    rd_chk(0, 2'd1, 16'h0030, "R5");
    rd_chk(1, 2'd1, 16'h0000, "R10");
    wreg(2'd1, 16'h003F);

    // R5 reversed bounds give an empty range
    wreg(2'd2, 16'h2000);
    wreg(2'd3, 16'h1000);
    bus(16'h1800, 1'b1, 1'b0);
    bus(16'h2000, 1'b1, 1'b0);
    rd_chk(0, 2'd1, 16'h0000, "R5");
    wreg(2'd1, 16'h003F);

    // R6 fetch mode
    wreg(2'd0, 16'd14);
    wreg(2'd2, 16'h3000);
    bus(16'h3000, 1'b1, 1'b0);
    rd_chk(0, 2'd1, 16'h0000, "R6");
    fetch(16'h3000);
    rd_chk(0, 2'd1, 16'h0001, "R6");
    bus(16'h3000, 1'b0, 1'b1);
    rd_chk(0, 2'd1, 16'h0001, "R6");

    // R7 hit wins over a simultaneous clear
    cyc(2'd1, 1'b1, 16'h0001, 16'h0, 1'b0, 1'b0, 1'b1, 16'h3000);
    rd_chk(0, 2'd1, 16'h0001, "R7");

    // R9 halt on fetch hit
    wreg(2'd0, 16'd15);
    fetch(16'h3000);
    check("R9", "halt on fetch hit", 32'(halt[0]), 1);
    bus(16'h0000, 1'b0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule